// File: doc/BRIEF.md
# Lockstep Chunk Branch and Call Sequencer

This block steers the instruction stream of a shader core whose threads run in groups of lanes that share one instruction. Each accepted operation is one control-flow slot that a decoder has already paired with an arithmetic instruction: nothing, a jump, a call, a return, or a join. Together with the slot comes one condition bit per lane. The sequencer holds the fetch address, the mask of lanes that are still live, and a hardware stack of saved contexts. A call therefore completes in one cycle, and software never manages return addresses.

Only the condition bits of live lanes count. When the live lanes agree, the operation is either taken for all of them or skipped, and no stack entry is made for a split. When they disagree on a jump, the sequencer records a split entry and runs the taken lanes first. A join, or a return that covers every live lane, then moves execution to the deferred lanes. A second join or return restores the whole group. Calls save the caller's mask and the resume address, which lets shaders nest and recurse until the stack depth is used up. The live mask is the write-enable for the register file: a lane whose bit is clear must not write back.

Operations arrive on a valid/ready handshake. `op_ready` drops only once the chunk has finished. An operation is consumed on a rising edge where both `op_valid` and `op_ready` are high. While `op_valid` is low, the sequencer keeps its state.

Top module: `cfu_seq`

## Requirements
- R1: After reset, `fetch_pc` equals START_PC (0), `act_mask` is all ones, `chunk_done` and `stk_ovf` are 0, and `op_ready` is 1.
- R2: Operation codes are NOP=0, JMP=1, CALL=2, RET=3, JOIN=4. An operation takes effect only on an edge where `op_valid` and `op_ready` are both high. With `op_valid` low, `fetch_pc` and `act_mask` hold.
- R3: NOP, and any JMP, CALL or RET whose condition is false on every live lane, advance `fetch_pc` by one and leave the mask unchanged. Condition bits of lanes outside `act_mask` are ignored.
- R4: A JMP whose condition is true on every live lane loads `op_target` and keeps the mask, without using the stack.
- R5: A JMP on which the live lanes disagree loads `op_target` and narrows the mask to the taken lanes. It saves the deferred lanes with resume address pc+1. The first JOIN moves to the deferred lanes at that address. The second JOIN restores the full mask, removes the entry and advances by one.
- R6: A CALL with at least one true live lane loads `op_target` within one cycle and narrows the mask to those lanes. It saves the caller's mask and the address pc+1.
- R7: A RET that is true on some but not all live lanes removes those lanes from the mask and advances by one.
- R8: A RET true on every live lane, with a call entry on top, resumes at the saved address with the caller's mask. Nested calls unwind in last-in, first-out order.
- R9: A RET true on every live lane, with a split entry on top, switches to the deferred lanes at their address on the first such event. On the second, it restores the full mask and keeps `fetch_pc`, so the same return is fetched again.
- R10: A push while DEPTH entries are held sets `stk_ovf`, which stays set until reset. The operation is suppressed (pc+1, mask kept) and stored entries stay intact.
- R11: A RET true on every live lane with an empty stack sets `chunk_done`, which stays set. `op_ready` goes low and further operations change nothing.
- R12: A JOIN with no split entry on top of the stack only advances `fetch_pc` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A control-flow slot is offered |
| op_ready | output | 1 | Slot can be accepted (low once done) |
| op_kind | input | 3 | Operation code (see R2) |
| op_cond | input | LANES | Per-lane condition bits |
| op_target | input | PC_W | Jump or call target address |
| fetch_pc | output | PC_W | Address of the instruction to fetch |
| act_mask | output | LANES | Live lanes; gates register writeback |
| chunk_done | output | 1 | Chunk has returned from its top level |
| stk_ovf | output | 1 | Sticky stack overflow flag |

## Verification
Every result shows up in the cycle after the accepting edge: `fetch_pc`, `act_mask`, `chunk_done` and `stk_ovf` are all registered, and there is no further stage. The bench drives each slot on a falling edge and holds it through one rising edge. It drops `op_valid` and samples the outputs 2 ns after that rising edge, which is away from both edges. So every check sees exactly one consumed operation. Hold and suppression cases are checked at that same point, one edge after the stimulus.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [2:0] {
    CFU_NOP  = 3'd0,
    CFU_JMP  = 3'd1,
    CFU_CALL = 3'd2,
    CFU_RET  = 3'd3,
    CFU_JOIN = 3'd4
  } cfu_op_e;

  typedef enum logic {
    ENT_CALL  = 1'b0,
    ENT_SPLIT = 1'b1
  } cfu_ent_e;

endpackage

// File: rtl/cfu_lane_eval.sv
module cfu_lane_eval #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] live,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] hit,
  output logic [LANES-1:0] miss,
  output logic             any_hit,
  output logic             all_hit
);

  // per-lane qualification of the condition by the live mask
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l]  = live[l] & cond[l];
    assign miss[l] = live[l] & ~cond[l];
  end

  assign any_hit = |hit;
  assign all_hit = (hit == live);

endmodule

// File: rtl/cfu_ret_stack.sv
module cfu_ret_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full,
  output logic         ovf
);

  localparam int SP_W = $clog2(DEPTH + 1);

  logic [SP_W-1:0] sp;
  logic [W-1:0]    slot_q [DEPTH];
  logic            push_ok;
  logic            pop_ok;

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push_ok && sp == SP_W'(g)) begin
        q <= push_data;
      end else if (upd && sp == SP_W'(g + 1)) begin
        q <= upd_data;
      end
    end
    assign slot_q[g] = q;
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == SP_W'(i + 1)) top_data = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (push_ok)      sp  <= sp + 1'b1;
      else if (pop_ok)  sp  <= sp - 1'b1;
    end
  end

endmodule

// File: rtl/cfu_seq.sv
module cfu_seq #(
  parameter int LANES    = 4,
  parameter int PC_W     = 12,
  parameter int DEPTH    = 8,
  parameter int START_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_kind,
  input  logic [LANES-1:0] op_cond,
  input  logic [PC_W-1:0]  op_target,
  output logic [PC_W-1:0]  fetch_pc,
  output logic [LANES-1:0] act_mask,
  output logic             chunk_done,
  output logic             stk_ovf
);
  import cfu_pkg::*;

  typedef struct packed {
    cfu_ent_e         kind;
    logic             phase;
    logic [LANES-1:0] defer;
    logic [LANES-1:0] whole;
    logic [PC_W-1:0]  addr;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic             done_q, done_d;

  logic [LANES-1:0] hit, miss;
  logic             any_hit, all_hit;

  logic             st_push, st_pop, st_upd;
  ent_t             push_ent, upd_ent, top_ent;
  logic [ENT_W-1:0] top_raw;
  logic             st_empty, st_full;

  logic             fire;
  cfu_op_e          kind;
  logic [PC_W-1:0]  pc_inc;

  assign op_ready = !done_q;
  assign fire     = op_valid && op_ready;
  assign kind     = cfu_op_e'(op_kind);
  assign pc_inc   = pc_q + 1'b1;
  assign top_ent  = ent_t'(top_raw);

  cfu_lane_eval #(.LANES(LANES)) u_eval (
    .live    (mask_q),
    .cond    (op_cond),
    .hit     (hit),
    .miss    (miss),
    .any_hit (any_hit),
    .all_hit (all_hit)
  );

  cfu_ret_stack #(.W(ENT_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_push),
    .push_data (ENT_W'(push_ent)),
    .pop       (st_pop),
    .upd       (st_upd),
    .upd_data  (ENT_W'(upd_ent)),
    .top_data  (top_raw),
    .empty     (st_empty),
    .full      (st_full),
    .ovf       (stk_ovf)
  );

  always_comb begin
    pc_d     = pc_q;
    mask_d   = mask_q;
    done_d   = done_q;
    st_push  = 1'b0;
    st_pop   = 1'b0;
    st_upd   = 1'b0;
    push_ent = '{kind: ENT_CALL, phase: 1'b0, defer: miss, whole: mask_q, addr: pc_inc};
    upd_ent  = top_ent;
    upd_ent.phase = 1'b1;

    if (fire) begin
      unique case (kind)
        CFU_JMP: begin
          if (!any_hit) begin
            pc_d = pc_inc;
          end else if (all_hit) begin
            pc_d = op_target;
          end else begin
            push_ent.kind = ENT_SPLIT;
            st_push = 1'b1;
            if (st_full) begin
              pc_d = pc_inc;
            end else begin
              pc_d   = op_target;
              mask_d = hit;
            end
          end
        end
        CFU_CALL: begin
          if (!any_hit) begin
            pc_d = pc_inc;
          end else begin
            st_push = 1'b1;
            if (st_full) begin
              pc_d = pc_inc;
            end else begin
              pc_d   = op_target;
              mask_d = hit;
            end
          end
        end
        CFU_RET: begin
          if (!any_hit) begin
            pc_d = pc_inc;
          end else if (!all_hit) begin
            mask_d = miss;
            pc_d   = pc_inc;
          end else if (st_empty) begin
            done_d = 1'b1;
          end else if (top_ent.kind == ENT_CALL) begin
            st_pop = 1'b1;
            pc_d   = top_ent.addr;
            mask_d = top_ent.whole;
          end else if (!top_ent.phase) begin
            st_upd = 1'b1;
            pc_d   = top_ent.addr;
            mask_d = top_ent.defer;
          end else begin
            // rejoined group refetches the same return
            st_pop = 1'b1;
            mask_d = top_ent.whole;
          end
        end
        CFU_JOIN: begin
          if (!st_empty && top_ent.kind == ENT_SPLIT) begin
            if (!top_ent.phase) begin
              st_upd = 1'b1;
              pc_d   = top_ent.addr;
              mask_d = top_ent.defer;
            end else begin
              st_pop = 1'b1;
              pc_d   = pc_inc;
              mask_d = top_ent.whole;
            end
          end else begin
            pc_d = pc_inc;
          end
        end
        default: pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC_W'(START_PC);
      mask_q <= '1;
      done_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      done_q <= done_d;
    end
  end

  assign fetch_pc   = pc_q;
  assign act_mask   = mask_q;
  assign chunk_done = done_q;

endmodule

// File: rtl/cfu_seq_checker.sv
module cfu_seq_checker #(
  parameter int LANES = 4,
  parameter int PC_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [2:0]       op_kind,
  input logic [LANES-1:0] op_cond,
  input logic [PC_W-1:0]  op_target,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [LANES-1:0] act_mask,
  input logic             chunk_done,
  input logic             stk_ovf
);

  logic fire;
  assign fire = op_valid && op_ready;

  // R2: idle cycles keep the fetch address and the lane mask
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(fetch_pc) && $stable(act_mask)));

  // R3: a branching slot false on every live lane just steps on
  a_r3_untaken_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op_kind == 3'd1 || op_kind == 3'd2 || op_kind == 3'd3) &&
     ((op_cond & act_mask) == '0))
    |=> (fetch_pc == PC_W'($past(fetch_pc) + 1'b1) && act_mask == $past(act_mask)));

  // R4: unanimous jump keeps the group whole
  a_r4_uniform_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_kind == 3'd1 && (op_cond & act_mask) == act_mask)
    |=> (fetch_pc == $past(op_target) && act_mask == $past(act_mask)));

  // R5: a running chunk always has a live lane
  a_r5_live_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !chunk_done |-> (act_mask != '0));

  // R10: overflow flag is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  // R11: finished chunk refuses slots and stays finished
  a_r11_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> !op_ready);

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> (chunk_done && $stable(fetch_pc) && $stable(act_mask)));

endmodule

bind cfu_seq cfu_seq_checker #(.LANES(LANES), .PC_W(PC_W)) u_cfu_seq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_kind    (op_kind),
  .op_cond    (op_cond),
  .op_target  (op_target),
  .fetch_pc   (fetch_pc),
  .act_mask   (act_mask),
  .chunk_done (chunk_done),
  .stk_ovf    (stk_ovf)
);

// File: tb/cfu_seq_tb_top.sv
`timescale 1ns/1ps
module cfu_seq_tb_top;

  localparam int LANES = 4;
  localparam int PC_W  = 12;
  localparam int DEPTH = 8;

  localparam logic [2:0] K_NOP  = 3'd0;
  localparam logic [2:0] K_JMP  = 3'd1;
  localparam logic [2:0] K_CALL = 3'd2;
  localparam logic [2:0] K_RET  = 3'd3;
  localparam logic [2:0] K_JOIN = 3'd4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [2:0]       op_kind = '0;
  logic [LANES-1:0] op_cond = '0;
  logic [PC_W-1:0]  op_target = '0;
  logic [PC_W-1:0]  fetch_pc;
  logic [LANES-1:0] act_mask;
  logic             chunk_done;
  logic             stk_ovf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cfu_seq #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(0)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_kind    (op_kind),
    .op_cond    (op_cond),
    .op_target  (op_target),
    .fetch_pc   (fetch_pc),
    .act_mask   (act_mask),
    .chunk_done (chunk_done),
    .stk_ovf    (stk_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int pc, input int mask);
    chk({tag, " pc"}, int'(fetch_pc), pc);
    chk({tag, " mask"}, int'(act_mask), mask);
  endtask

  // drive one slot on a falling edge, consume on the rising edge, sample 2 ns later
  task automatic issue(input logic [2:0] k, input logic [LANES-1:0] c, input int tgt);
    @(negedge clk);
    op_valid  = 1'b1;
    op_kind   = k;
    op_cond   = c;
    op_target = PC_W'(tgt);
    @(posedge clk);
    #2;
    op_valid  = 1'b0;
  endtask

  task automatic do_reset();
    op_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1 reset", 0, 4'hF);
    chk("R1 done", int'(chunk_done), 0);
    chk("R1 ovf", int'(stk_ovf), 0);
    chk("R1 ready", int'(op_ready), 1);
  endtask

  task automatic t_sequential();
    issue(K_NOP, 4'h0, 0);
    chk_state("R3 nop", 1, 4'hF);
    repeat (2) @(negedge clk);
    chk_state("R2 idle hold", 1, 4'hF);
    issue(K_JMP, 4'h0, 99);
    chk_state("R3 jmp untaken", 2, 4'hF);
    issue(K_CALL, 4'h0, 99);
    chk_state("R3 call untaken", 3, 4'hF);
    issue(K_RET, 4'h0, 0);
    chk_state("R3 ret untaken", 4, 4'hF);
  endtask

  task automatic t_uniform_jump();
    issue(K_JMP, 4'hF, 40);
    chk_state("R4 uniform jump", 40, 4'hF);
  endtask

  task automatic t_divergent();
    issue(K_JMP, 4'h3, 80);
    chk_state("R5 split taken", 80, 4'h3);
    issue(K_NOP, 4'h0, 0);
    chk_state("R5 taken body", 81, 4'h3);
    issue(K_JOIN, 4'h0, 0);
    chk_state("R5 first join", 41, 4'hC);
    issue(K_NOP, 4'h0, 0);
    chk_state("R5 deferred body", 42, 4'hC);
    issue(K_JOIN, 4'h0, 0);
    chk_state("R5 second join", 43, 4'hF);
    issue(K_JOIN, 4'h0, 0);
    chk_state("R12 join no split", 44, 4'hF);
  endtask

  task automatic t_call_return();
    issue(K_CALL, 4'h6, 200);
    chk_state("R6 call", 200, 4'h6);
    issue(K_RET, 4'h4, 0);
    chk_state("R7 partial ret", 201, 4'h2);
    issue(K_RET, 4'h2, 0);
    chk_state("R8 ret to caller", 45, 4'hF);
    issue(K_CALL, 4'hF, 300);
    chk_state("R6 outer call", 300, 4'hF);
    issue(K_CALL, 4'h1, 400);
    chk_state("R6 inner call", 400, 4'h1);
    // inactive lanes' condition bits are set but must be ignored (R3)
    issue(K_RET, 4'hF, 0);
    chk_state("R8 inner ret", 301, 4'hF);
    issue(K_RET, 4'hF, 0);
    chk_state("R8 outer ret", 46, 4'hF);
  endtask

  task automatic t_ret_in_split();
    issue(K_JMP, 4'h8, 500);
    chk_state("R5 split for ret", 500, 4'h8);
    issue(K_RET, 4'h8, 0);
    chk_state("R9 ret to deferred", 47, 4'h7);
    issue(K_RET, 4'h7, 0);
    chk_state("R9 ret rejoin", 47, 4'hF);
    issue(K_NOP, 4'h0, 0);
    chk_state("R9 after rejoin", 48, 4'hF);
  endtask

  task automatic t_overflow_and_done();
    for (int k = 0; k < DEPTH; k++) begin
      issue(K_CALL, 4'hF, 600 + 10 * k);
    end
    chk_state("R8 deep nest", 670, 4'hF);
    chk("R10 no ovf at depth", int'(stk_ovf), 0);
    issue(K_CALL, 4'hF, 900);
    chk("R10 ovf set", int'(stk_ovf), 1);
    chk_state("R10 call suppressed", 671, 4'hF);
    for (int j = DEPTH - 1; j >= 0; j--) begin
      issue(K_RET, 4'hF, 0);
      chk("R10 unwind pc", int'(fetch_pc), (j == 0) ? 49 : 600 + 10 * (j - 1) + 1);
    end
    chk("R10 ovf sticky", int'(stk_ovf), 1);
    chk("R11 not done yet", int'(chunk_done), 0);
    issue(K_RET, 4'hF, 0);
    chk("R11 done", int'(chunk_done), 1);
    chk("R11 ready low", int'(op_ready), 0);
    issue(K_JMP, 4'hF, 123);
    chk_state("R11 ignored after done", 49, 4'hF);
    chk("R11 done sticky", int'(chunk_done), 1);
    do_reset();
    chk("R1 ovf cleared", int'(stk_ovf), 0);
    chk("R1 done cleared", int'(chunk_done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequential();
    t_uniform_jump();
    t_divergent();
    t_call_return();
    t_ret_in_split();
    t_overflow_and_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule